// File: doc/BRIEF.md
# Serial Display Command and Pixel Byte Decoder

This block sits at the receiving end of a serial link to a small graphics display controller. A shifter assembles bits into bytes while the active-high select line is held. Each byte is then routed by a data/command line that is captured with the byte's last bit. Data bytes go straight out as one-cycle pixel strobes toward the display RAM address generator. Command bytes go to a small engine.

The engine treats the first command byte as an opcode. It looks up how many argument bytes that opcode needs and collects them. When the last one arrives it executes the opcode and waits for a new one. Three opcodes change state the address generator uses: the column window, the row window and the remap register. Analog tuning commands and the grey-scale table are parsed so that framing stays correct, and their arguments are dropped. An opcode the engine does not know finishes on the spot and raises a one-cycle error strobe.

Top module: `disp_byte_decoder`

## Requirements
- R1: While `cs_i` is high, `sdi_i` is sampled on each rising `clk` edge, most significant bit first. The cycle after the eighth bit is sampled, the byte appears on `pix_data_o`, and `pix_valid_o` pulses for one cycle if `dc_i` was high (1 = data) with that eighth bit.
- R2: Bringing `cs_i` low discards a partly shifted byte. The next byte starts from bit 7.
- R3: Command byte 0x15 followed by two arguments (start, then end) loads the column window as start mod 64 and end mod 64. One cycle after the byte that completes it is captured, the window outputs update and `col_load_o` pulses for one cycle.
- R4: Command byte 0x75 followed by two arguments (start, then end) loads the row window as start mod 80 and end mod 80. The outputs update and `row_load_o` pulses with the same timing as R3.
- R5: Command byte 0xA0 followed by one argument stores that argument in `remap_o`. `remap_o` changes at no other time.
- R6: Opcodes 0x81, 0xA1, 0xA2, 0xA8, 0xAD, 0xB1, 0xB2, 0xB3, 0xBC, 0xBE and 0xBF consume exactly one argument and change no output. The byte after that argument is decoded as an opcode.
- R7: Opcode 0xB8 consumes exactly eight arguments and changes no output, even when those arguments look like opcodes.
- R8: Opcodes 0x84 to 0x86, 0xA4 to 0xA7, 0xAE, 0xAF, 0xE3 and 0xFF complete with no argument and raise no error. The next command byte is an opcode.
- R9: Any other opcode completes with no argument, and `err_o` pulses for one cycle, one cycle after the opcode byte is captured.
- R10: Data bytes that arrive while a command is collecting arguments still produce pixel strobes. They neither reset nor advance the argument count.
- R11: After reset the column window is 0 to 63, the row window is 0 to 79, `remap_o` is 0, and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Link select, active high |
| sdi_i | input | 1 | Serial data, MSB first |
| dc_i | input | 1 | 1 = data byte, 0 = command byte |
| pix_valid_o | output | 1 | One-cycle strobe for a received data byte |
| pix_data_o | output | 8 | Last received byte |
| col_start_o | output | 6 | Column window start |
| col_end_o | output | 6 | Column window end |
| row_start_o | output | 7 | Row window start |
| row_end_o | output | 7 | Row window end |
| remap_o | output | 8 | Remap setting |
| col_load_o | output | 1 | Column window was just loaded |
| row_load_o | output | 1 | Row window was just loaded |
| err_o | output | 1 | Unknown opcode strobe |

## Verification
The two failure classes show up differently at the ports. A wrong bit count or a lost select reset shifts every later byte and turns pixel data into garbage within eight cycles. A wrong argument count surfaces more slowly. It stays hidden until a later opcode is swallowed as an argument or an argument is run as an opcode. That shows up as a missing or spurious load strobe, a wrong window, or a false error one cycle after the misframed byte. The bench therefore follows each discard-type command with a remap write, so that misframing becomes visible at once.

// File: rtl/disp_dec_pkg.sv
package disp_dec_pkg;

   localparam logic [7:0] OP_COL_WIN   = 8'h15;
   localparam logic [7:0] OP_ROW_WIN   = 8'h75;
   localparam logic [7:0] OP_REMAP     = 8'hA0;
   localparam int         MAX_ARGS     = 8;
   localparam int         ARG_CNT_W    = $clog2(MAX_ARGS + 1);

   typedef struct packed {
      logic                 known;
      logic [ARG_CNT_W-1:0] nargs;
   } op_info_t;

   function automatic op_info_t op_lookup(input logic [7:0] op);
      op_info_t r;
      r.known = 1'b1;
      r.nargs = '0;
      case (op)
         OP_COL_WIN, OP_ROW_WIN:
            r.nargs = ARG_CNT_W'(2);
         OP_REMAP, 8'h81, 8'hA1, 8'hA2, 8'hA8, 8'hAD,
         8'hB1, 8'hB2, 8'hB3, 8'hBC, 8'hBE, 8'hBF:
            r.nargs = ARG_CNT_W'(1);
         8'hB8:
            r.nargs = ARG_CNT_W'(MAX_ARGS);
         8'h84, 8'h85, 8'h86, 8'hA4, 8'hA5, 8'hA6, 8'hA7,
         8'hAE, 8'hAF, 8'hE3, 8'hFF:
            r.nargs = '0;
         default:
            r.known = 1'b0;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/disp_bit_shifter.sv
module disp_bit_shifter #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_i,
   input  logic              sdi_i,
   input  logic              dc_i,
   output logic              byte_vld_o,
   output logic [BYTE_W-1:0] byte_o,
   output logic              byte_dc_o
);
   localparam int CNT_W = $clog2(BYTE_W);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

   if (BYTE_W < 2) begin : g_bad_width
      $error("disp_bit_shifter: BYTE_W must be at least 2");
   end

   logic [CNT_W-1:0]  bit_cnt_q;
   logic [BYTE_W-2:0] shreg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt_q  <= '0;
         shreg_q    <= '0;
         byte_vld_o <= 1'b0;
         byte_o     <= '0;
         byte_dc_o  <= 1'b0;
      end else begin
         byte_vld_o <= 1'b0;
         if (!cs_i) begin
            bit_cnt_q <= '0;
         end else if (bit_cnt_q == LAST_BIT) begin
            bit_cnt_q  <= '0;
            byte_o     <= {shreg_q, sdi_i};
            byte_dc_o  <= dc_i;
            byte_vld_o <= 1'b1;
         end else begin
            bit_cnt_q <= bit_cnt_q + 1'b1;
            shreg_q   <= {shreg_q[BYTE_W-3:0], sdi_i};
         end
      end
   end

   // R2
   cs_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_i |=> !byte_vld_o);

   // R1
   single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byte_vld_o |=> !byte_vld_o);

endmodule

// File: rtl/disp_cmd_engine.sv
module disp_cmd_engine
   import disp_dec_pkg::*;
#(
   parameter int COLS = 64,
   parameter int ROWS = 80,
   parameter int COL_W = $clog2(COLS),
   parameter int ROW_W = $clog2(ROWS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             vld_i,
   input  logic [7:0]       byte_i,
   input  logic             dc_i,
   output logic [COL_W-1:0] col_start_o,
   output logic [COL_W-1:0] col_end_o,
   output logic [ROW_W-1:0] row_start_o,
   output logic [ROW_W-1:0] row_end_o,
   output logic [7:0]       remap_o,
   output logic             col_ld_o,
   output logic             row_ld_o,
   output logic             err_o
);
   if (COLS < 2 || COLS > 256 || ROWS < 2 || ROWS > 256) begin : g_bad_geom
      $error("disp_cmd_engine: COLS and ROWS must lie in 2..256");
   end

   function automatic logic [COL_W-1:0] col_wrap(input logic [7:0] b);
      return COL_W'(32'(b) % 32'(COLS));
   endfunction

   function automatic logic [ROW_W-1:0] row_wrap(input logic [7:0] b);
      return ROW_W'(32'(b) % 32'(ROWS));
   endfunction

   op_info_t             info;
   logic                 take_cmd;
   logic                 busy_q;
   logic [7:0]           op_q;
   logic [7:0]           arg0_q;
   logic [ARG_CNT_W-1:0] arg_cnt_q;
   logic [ARG_CNT_W-1:0] need_q;
   logic [7:0]           first_arg;
   logic                 last_arg;

   assign info      = op_lookup(byte_i);
   assign take_cmd  = vld_i && !dc_i;
   assign first_arg = (arg_cnt_q == '0) ? byte_i : arg0_q;
   assign last_arg  = (arg_cnt_q + 1'b1) == need_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q      <= 1'b0;
         op_q        <= '0;
         arg0_q      <= '0;
         arg_cnt_q   <= '0;
         need_q      <= '0;
         col_start_o <= '0;
         col_end_o   <= COL_W'(COLS - 1);
         row_start_o <= '0;
         row_end_o   <= ROW_W'(ROWS - 1);
         remap_o     <= '0;
         col_ld_o    <= 1'b0;
         row_ld_o    <= 1'b0;
         err_o       <= 1'b0;
      end else begin
         col_ld_o <= 1'b0;
         row_ld_o <= 1'b0;
         err_o    <= 1'b0;
         if (take_cmd) begin
            if (!busy_q) begin
               op_q <= byte_i;
               if (info.nargs == '0) begin
                  err_o <= !info.known;
               end else begin
                  busy_q    <= 1'b1;
                  need_q    <= info.nargs;
                  arg_cnt_q <= '0;
               end
            end else begin
               if (arg_cnt_q == '0) arg0_q <= byte_i;
               if (last_arg) begin
                  busy_q    <= 1'b0;
                  arg_cnt_q <= '0;
                  case (op_q)
                     OP_COL_WIN: begin
                        col_start_o <= col_wrap(first_arg);
                        col_end_o   <= col_wrap(byte_i);
                        col_ld_o    <= 1'b1;
                     end
                     OP_ROW_WIN: begin
                        row_start_o <= row_wrap(first_arg);
                        row_end_o   <= row_wrap(byte_i);
                        row_ld_o    <= 1'b1;
                     end
                     OP_REMAP: remap_o <= byte_i;
                     default: ;
                  endcase
               end else begin
                  arg_cnt_q <= arg_cnt_q + 1'b1;
               end
            end
         end
      end
   end

   // R9
   err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> $past(vld_i && !dc_i));

   // R3
   col_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      col_ld_o |-> $past(vld_i && !dc_i));

   // R4
   row_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      row_ld_o |-> $past(vld_i && !dc_i));

   // R5
   remap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(vld_i) |-> $stable(remap_o));

   // R10
   data_no_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(vld_i && dc_i) |-> !(col_ld_o || row_ld_o || err_o));

endmodule

// File: rtl/disp_byte_decoder.sv
module disp_byte_decoder #(
   parameter int COLS    = 64,
   parameter int ROWS    = 80,
   parameter bit PIX_REG = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs_i,
   input  logic       sdi_i,
   input  logic       dc_i,
   output logic       pix_valid_o,
   output logic [7:0] pix_data_o,
   output logic [5:0] col_start_o,
   output logic [5:0] col_end_o,
   output logic [6:0] row_start_o,
   output logic [6:0] row_end_o,
   output logic [7:0] remap_o,
   output logic       col_load_o,
   output logic       row_load_o,
   output logic       err_o
);
   localparam int COL_W = $clog2(COLS);
   localparam int ROW_W = $clog2(ROWS);

   if (COL_W != 6 || ROW_W != 7) begin : g_bad_ports
      $error("disp_byte_decoder: geometry must fit the 6-bit column and 7-bit row ports");
   end

   logic       byte_vld;
   logic [7:0] byte_val;
   logic       byte_dc;

   disp_bit_shifter #(.BYTE_W(8)) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_i       (cs_i),
      .sdi_i      (sdi_i),
      .dc_i       (dc_i),
      .byte_vld_o (byte_vld),
      .byte_o     (byte_val),
      .byte_dc_o  (byte_dc)
   );

   disp_cmd_engine #(.COLS(COLS), .ROWS(ROWS)) u_engine (
      .clk         (clk),
      .rst_n       (rst_n),
      .vld_i       (byte_vld),
      .byte_i      (byte_val),
      .dc_i        (byte_dc),
      .col_start_o (col_start_o),
      .col_end_o   (col_end_o),
      .row_start_o (row_start_o),
      .row_end_o   (row_end_o),
      .remap_o     (remap_o),
      .col_ld_o    (col_load_o),
      .row_ld_o    (row_load_o),
      .err_o       (err_o)
   );

   if (PIX_REG) begin : g_pix_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pix_valid_o <= 1'b0;
            pix_data_o  <= '0;
         end else begin
            pix_valid_o <= byte_vld && byte_dc;
            pix_data_o  <= byte_val;
         end
      end
   end else begin : g_pix_comb
      assign pix_valid_o = byte_vld && byte_dc;
      assign pix_data_o  = byte_val;
   end

endmodule

// File: tb/disp_byte_decoder_bench.sv
module disp_byte_decoder_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs = 1'b0, sdi = 1'b0, dc = 1'b0;
   logic       pix_valid_o;
   logic [7:0] pix_data_o;
   logic [5:0] col_start_o, col_end_o;
   logic [6:0] row_start_o, row_end_o;
   logic [7:0] remap_o;
   logic       col_load_o, row_load_o, err_o;

   int tests = 0, fails = 0;

   always #5 clk = ~clk;

   disp_byte_decoder u_disp_byte_decoder (
      .clk(clk), .rst_n(rst_n), .cs_i(cs), .sdi_i(sdi), .dc_i(dc),
      .pix_valid_o(pix_valid_o), .pix_data_o(pix_data_o),
      .col_start_o(col_start_o), .col_end_o(col_end_o),
      .row_start_o(row_start_o), .row_end_o(row_end_o),
      .remap_o(remap_o), .col_load_o(col_load_o), .row_load_o(row_load_o),
      .err_o(err_o));

   task automatic chk(input string tag, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural model, built from the requirements
   function automatic int argc(input int b);
      case (b)
         'h15, 'h75: return 2;
         'hA0, 'h81, 'hA1, 'hA2, 'hA8, 'hAD, 'hB1, 'hB2, 'hB3, 'hBC, 'hBE, 'hBF: return 1;
         'hB8: return 8;
         'h84, 'h85, 'h86, 'hA4, 'hA5, 'hA6, 'hA7, 'hAE, 'hAF, 'hE3, 'hFF: return 0;
         default: return -1;
      endcase
   endfunction

   int m_nb, m_acc, m_pend, m_pdc, m_pbyte, m_busy, m_op, m_cnt, m_need, m_arg0;
   int e_cs, e_ce, e_rs, e_re, e_rm, e_cl, e_rl, e_er, e_pv, e_pd;

   task automatic model_byte(input int b);
      int n;
      if (!m_busy) begin
         m_op = b;
         n = argc(b);
         if (n <= 0) e_er = (n < 0);
         else begin m_busy = 1; m_need = n; m_cnt = 0; end
      end else begin
         if (m_cnt == 0) m_arg0 = b;
         m_cnt++;
         if (m_cnt == m_need) begin
            m_busy = 0;
            if (m_op == 'h15) begin e_cs = m_arg0 % 64; e_ce = b % 64; e_cl = 1; end
            if (m_op == 'h75) begin e_rs = m_arg0 % 80; e_re = b % 80; e_rl = 1; end
            if (m_op == 'hA0) e_rm = b;
         end
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_nb = 0; m_acc = 0; m_pend = 0; m_pdc = 0; m_pbyte = 0;
         m_busy = 0; m_op = 0; m_cnt = 0; m_need = 0; m_arg0 = 0;
         e_cs = 0; e_ce = 63; e_rs = 0; e_re = 79; e_rm = 0;
         e_cl = 0; e_rl = 0; e_er = 0; e_pv = 0; e_pd = 0;
      end else begin
         e_cl = 0; e_rl = 0; e_er = 0;
         if (m_pend && !m_pdc) model_byte(m_pbyte);
         m_pend = 0; e_pv = 0;
         if (cs) begin
            m_acc = ((m_acc << 1) | int'(sdi)) & 255;
            m_nb++;
            if (m_nb == 8) begin
               m_nb = 0; m_pend = 1; m_pdc = int'(dc); m_pbyte = m_acc;
               e_pv = int'(dc); e_pd = m_acc;
            end
         end else m_nb = 0;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         chk("R1 pix_valid", int'(pix_valid_o), e_pv);
         if (e_pv != 0) chk("R1 pix_data", int'(pix_data_o), e_pd);
         chk("R3 col_start", int'(col_start_o), e_cs);
         chk("R3 col_end", int'(col_end_o), e_ce);
         chk("R4 row_start", int'(row_start_o), e_rs);
         chk("R4 row_end", int'(row_end_o), e_re);
         chk("R5 remap", int'(remap_o), e_rm);
         chk("R3 col_load", int'(col_load_o), e_cl);
         chk("R4 row_load", int'(row_load_o), e_rl);
         chk("R9 err", int'(err_o), e_er);
      end
   end

   task automatic send(input logic d, input logic [7:0] b);
      for (int i = 7; i >= 0; i--) begin
         @(negedge clk);
         cs = 1'b1; dc = d; sdi = b[i];
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         cs = 1'b0; sdi = 1'b0;
      end
   endtask

   int err_seen = 0;
   always @(posedge clk) if (rst_n && err_o) err_seen++;

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk("R11 col_start", int'(col_start_o), 0);
      chk("R11 col_end", int'(col_end_o), 63);
      chk("R11 row_end", int'(row_end_o), 79);
      chk("R11 remap", int'(remap_o), 0);
      chk("R11 strobes", int'({pix_valid_o, col_load_o, row_load_o, err_o}), 0);
      // R1 back-to-back data bytes
      send(1'b1, 8'hA5); send(1'b1, 8'h3C); send(1'b1, 8'h01); idle(2);
      // R2 partial byte dropped
      send(1'b1, 8'hFF); idle(0);
      for (int i = 0; i < 3; i++) begin @(negedge clk); cs = 1'b1; sdi = 1'b1; end
      idle(2);
      send(1'b1, 8'h5A); idle(1);
      // R3 column window with wrap
      send(1'b0, 8'h15); send(1'b0, 8'h45); send(1'b0, 8'h0A); idle(3);
      chk("R3 col_start explicit", int'(col_start_o), 5);
      chk("R3 col_end explicit", int'(col_end_o), 10);
      // R4 row window with wrap
      send(1'b0, 8'h75); send(1'b0, 8'hA5); send(1'b0, 8'h4F); idle(3);
      chk("R4 row_start explicit", int'(row_start_o), 5);
      chk("R4 row_end explicit", int'(row_end_o), 79);
      // R5 remap
      send(1'b0, 8'hA0); send(1'b0, 8'h52); idle(3);
      chk("R5 remap explicit", int'(remap_o), 'h52);
      // R6 one-arg discard swallowing an opcode-like byte
      send(1'b0, 8'h81); send(1'b0, 8'h15); send(1'b0, 8'hA0); send(1'b0, 8'h07); idle(3);
      chk("R6 remap after discard", int'(remap_o), 7);
      chk("R6 col unchanged", int'(col_start_o), 5);
      send(1'b0, 8'hBF); send(1'b0, 8'h75); send(1'b0, 8'hA0); send(1'b0, 8'h08); idle(3);
      chk("R6 remap after 0xBF", int'(remap_o), 8);
      // R7 eight discarded arguments
      send(1'b0, 8'hB8);
      for (int i = 0; i < 8; i++) send(1'b0, 8'h15);
      send(1'b0, 8'hA0); send(1'b0, 8'h33); idle(3);
      chk("R7 remap after table", int'(remap_o), 'h33);
      chk("R7 col unchanged", int'(col_end_o), 10);
      // R8 zero-arg opcodes
      send(1'b0, 8'hA4); send(1'b0, 8'hE3); send(1'b0, 8'hFF);
      send(1'b0, 8'hA0); send(1'b0, 8'h11); idle(3);
      chk("R8 remap after no-arg ops", int'(remap_o), 'h11);
      chk("R8 no error", err_seen, 0);
      // R9 unknown opcode
      send(1'b0, 8'h00); send(1'b0, 8'hA0); send(1'b0, 8'h22); idle(3);
      chk("R9 error count", err_seen, 1);
      chk("R9 remap after unknown", int'(remap_o), 'h22);
      // R10 data in the middle of a command
      send(1'b0, 8'h15); send(1'b0, 8'h20); send(1'b1, 8'h99); send(1'b0, 8'h30); idle(3);
      chk("R10 col_start", int'(col_start_o), 'h20);
      chk("R10 col_end", int'(col_end_o), 'h30);
      idle(4);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule